// File: doc/BRIEF.md
# Transmit Length and Start Controller

This block sits between a host register port and a contactless reader's bit-level transmitter. The host programs a message length, pushes data bytes into a 12-entry transmit FIFO and issues a transmit command. The block decides when the message starts, counts out the whole bytes and an optional trailing group of bits, and shifts them out one bit per strobe from the bit clock. Framing, parity, modulation and the physical host bus are handled elsewhere.

Transmission can be started in either order. If the command comes first, the block arms itself and starts when the first byte arrives. If the data is loaded first, it starts when the command arrives. For long messages the block warns the host when the FIFO runs low. When the final bit leaves, it raises a completion flag. Both flags live in a read-to-clear status register that drives the interrupt line.

Top module: `txl_tx_ctrl`

## Requirements
- R1: The length is held in two registers that the host can read back. At address 0x1D sit bits 11:4 of a 12-bit whole-byte count. At address 0x1E, bits 7:4 hold count bits 3:0, bit 0 flags a trailing partial byte, and bits 3:1 give its bit count N. A flag with N = 0 means there is no partial byte.
- R2: A write to address 0x00 with bit 0 set (and bit 1 clear) is the transmit command. If the FIFO already holds data, transmission starts on that write.
- R3: A transmit command that meets an empty FIFO arms the block. The next byte written to address 0x1F starts transmission.
- R4: Bytes are sent LSB first in FIFO order: all whole bytes, then the low N bits of the partial byte. A strobe on `bit_stb` that has a bit ready produces `tx_bit_vld` = 1 and that bit on `tx_bit` in the next cycle. After each byte boundary, one cycle is needed to fetch the next byte.
- R5: A strobe with no bit ready sends nothing. This covers an empty FIFO mid-message, after the end and while idle. `tx_bit_vld` and `tx_bit` both stay 0 and the message resumes when data arrives.
- R6: When the last bit is sent, bit 7 of the status register at 0x0C is set, `irq` is raised and `tx_busy` falls in the same cycle.
- R7: Starting with a zero byte count and no partial byte completes at once. It sets status bit 7 and leaves `tx_busy` low.
- R8: While sending, status bit 5 is set each time this condition becomes true: FIFO occupancy is 3 or less and the number of bytes not yet taken from the FIFO exceeds that occupancy.
- R9: Reading address 0x0C returns the status flags in `reg_rdata` on the next cycle and clears them. `irq` is high exactly while a flag is set.
- R10: A write to 0x00 with bit 1 set empties the FIFO, stops any transmission and cancels an armed start. The length registers and the status flags are kept.
- R11: Length register writes while `tx_busy` is high are ignored. Both the readback and the message in progress are unaffected.
- R12: After reset the FIFO is empty and the block is idle. All outputs are 0 and both length registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| bit_stb | input | 1 | One-cycle bit-clock strobe |
| tx_bit | output | 1 | Serial data bit, 0 when no bit is sent |
| tx_bit_vld | output | 1 | `tx_bit` carries a bit this cycle |
| tx_busy | output | 1 | A message is being sent |
| irq | output | 1 | Interrupt, high while any status flag is set |

## Verification
Register writes, commands and flag updates all take effect at the clock edge that samples the write or event. Status flags, `irq` and `tx_busy` can therefore be checked right after that edge. A sent bit appears on `tx_bit_vld`/`tx_bit` one cycle after its strobe, and read data arrives one cycle after `reg_rd`. The bench drives on falling edges and samples at the falling edge that follows the edge of interest. It spaces strobes three cycles apart so that the one-cycle byte fetch never falls on a strobe. The only check that depends on the fetch slot is the FIFO-low flag, and it is read several strobes after the ninth byte fetch, when the flag is already settled.

// File: rtl/txl_pkg.sv
package txl_pkg;

  localparam logic [7:0] ADDR_CMD    = 8'h00;
  localparam logic [7:0] ADDR_IRQ    = 8'h0C;
  localparam logic [7:0] ADDR_LEN_HI = 8'h1D;
  localparam logic [7:0] ADDR_LEN_LO = 8'h1E;
  localparam logic [7:0] ADDR_FIFO   = 8'h1F;

  localparam int CMD_TX_BIT   = 0;
  localparam int CMD_RST_BIT  = 1;
  localparam int IRQ_DONE_BIT = 7;
  localparam int IRQ_LOW_BIT  = 5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SEND  = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic [11:0] nbytes;
    logic        part;
    logic [2:0]  pbits;
  } tx_len_t;

  // Assemble the message length from the two host registers.
  function automatic tx_len_t decode_len(input logic [7:0] hi, input logic [7:0] lo);
    tx_len_t l;
    l.nbytes = {hi, lo[7:4]};
    l.pbits  = lo[3:1];
    l.part   = lo[0] && (lo[3:1] != 3'd0);
    return l;
  endfunction

  function automatic logic len_is_empty(input tx_len_t l);
    return (l.nbytes == 12'd0) && !l.part;
  endfunction

  // Bytes still to be taken from the FIFO.
  function automatic logic [12:0] bytes_pending(input logic [11:0] whole, input logic part);
    return {1'b0, whole} + 13'(part);
  endfunction

endpackage

// File: rtl/txl_fifo.sv
module txl_fifo #(
  parameter int DEPTH = 12,
  parameter int W     = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          push_ok,
  output logic [CW-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          pop_ok;

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    empty   = (count == '0);
    push_ok = push && !flush && (count != FULL_CNT);
    pop_ok  = pop && !flush && !empty;
    dout    = mem[rp];
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= next_ptr(wp);
      if (pop_ok)  rp <= next_ptr(rp);
      if (push_ok && !pop_ok)      count <= count + CW'(1);
      else if (pop_ok && !push_ok) count <= count - CW'(1);
    end
  end

endmodule

// File: rtl/txl_seq.sv
module txl_seq
  import txl_pkg::*;
#(
  parameter int LOW_MARK = 3,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cmd_tx,
  input  logic          push_acc,
  input  tx_len_t       len,
  input  logic          fifo_empty,
  input  logic [CW-1:0] fifo_count,
  input  logic [7:0]    fifo_head,
  input  logic          bit_stb,
  output logic          pop,
  output logic          tx_bit,
  output logic          tx_vld,
  output logic          busy,
  output logic          start_evt,
  output logic          done_evt,
  output logic          low_evt,
  output logic          len_zero
);
  localparam logic [CW-1:0] LOW_CNT = CW'(LOW_MARK);

  seq_state_t  st;
  logic [11:0] bytes_left;
  logic        part_pend;
  logic [2:0]  pbits;
  logic [7:0]  sh;
  logic [3:0]  sh_cnt;
  logic        low_q;

  logic        arm_evt, more, shift, last_shift, low_cond;
  logic [12:0] pending;

  always_comb begin
    len_zero   = len_is_empty(len);
    busy       = (st == ST_SEND);
    start_evt  = !clr && (((st == ST_IDLE) && cmd_tx && !fifo_empty) ||
                          ((st == ST_ARMED) && push_acc));
    arm_evt    = !clr && (st == ST_IDLE) && cmd_tx && fifo_empty;
    more       = (bytes_left != 12'd0) || part_pend;
    pop        = !clr && busy && (sh_cnt == 4'd0) && more && !fifo_empty;
    shift      = !clr && busy && bit_stb && (sh_cnt != 4'd0);
    last_shift = shift && (sh_cnt == 4'd1) && !more;
    done_evt   = (start_evt && len_zero) || last_shift;
    pending    = bytes_pending(bytes_left, part_pend);
    low_cond   = busy && (fifo_count <= LOW_CNT) && (pending > 13'(fifo_count));
    low_evt    = !clr && low_cond && !low_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st         <= ST_IDLE;
      bytes_left <= '0;
      part_pend  <= 1'b0;
      pbits      <= '0;
      sh         <= '0;
      sh_cnt     <= '0;
      low_q      <= 1'b0;
      tx_vld     <= 1'b0;
      tx_bit     <= 1'b0;
    end else begin
      tx_vld <= shift;
      tx_bit <= shift ? sh[0] : 1'b0;
      low_q  <= low_cond;
      if (shift) begin
        sh     <= sh >> 1;
        sh_cnt <= sh_cnt - 4'd1;
      end
      if (pop) begin
        sh <= fifo_head;
        if (bytes_left != 12'd0) begin
          sh_cnt     <= 4'd8;
          bytes_left <= bytes_left - 12'd1;
        end else begin
          sh_cnt    <= {1'b0, pbits};
          part_pend <= 1'b0;
        end
      end
      if (start_evt) begin
        if (len_zero) begin
          st <= ST_IDLE;
        end else begin
          st         <= ST_SEND;
          bytes_left <= len.nbytes;
          part_pend  <= len.part;
          pbits      <= len.pbits;
          sh_cnt     <= '0;
        end
      end else if (arm_evt) begin
        st <= ST_ARMED;
      end else if (last_shift) begin
        st <= ST_IDLE;
      end
    end
  end

endmodule

// File: rtl/txl_irq.sv
module txl_irq
  import txl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done_evt,
  input  logic       low_evt,
  input  logic       rd_clr,
  output logic [7:0] status,
  output logic       irq
);
  logic [7:0] set_vec;

  always_comb begin
    set_vec               = '0;
    set_vec[IRQ_DONE_BIT] = done_evt;
    set_vec[IRQ_LOW_BIT]  = low_evt;
    irq                   = |status;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (rd_clr ? 8'h00 : status) | set_vec;
  end

endmodule

// File: rtl/txl_tx_ctrl.sv
module txl_tx_ctrl
  import txl_pkg::*;
#(
  parameter int FIFO_DEPTH = 12,
  parameter int LOW_MARK   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       bit_stb,
  output logic       tx_bit,
  output logic       tx_bit_vld,
  output logic       tx_busy,
  output logic       irq
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [7:0]    len_hi, len_lo;
  tx_len_t       len;
  logic          cmd_wr, cmd_tx, cmd_clr, fifo_push, push_acc, rd_clr;
  logic          fifo_empty, pop;
  logic [7:0]    fifo_head;
  logic [CW-1:0] fifo_count;
  logic          start_evt, done_evt, low_evt, len_zero;
  logic [7:0]    status;

  always_comb begin
    cmd_wr    = reg_wr && (reg_addr == ADDR_CMD);
    cmd_clr   = cmd_wr && reg_wdata[CMD_RST_BIT];
    cmd_tx    = cmd_wr && reg_wdata[CMD_TX_BIT] && !reg_wdata[CMD_RST_BIT];
    fifo_push = reg_wr && (reg_addr == ADDR_FIFO);
    rd_clr    = reg_rd && (reg_addr == ADDR_IRQ);
    len       = decode_len(len_hi, len_lo);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_hi <= '0;
      len_lo <= '0;
    end else if (reg_wr && !tx_busy) begin
      if (reg_addr == ADDR_LEN_HI) len_hi <= reg_wdata;
      if (reg_addr == ADDR_LEN_LO) len_lo <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        ADDR_IRQ:    reg_rdata <= status;
        ADDR_LEN_HI: reg_rdata <= len_hi;
        ADDR_LEN_LO: reg_rdata <= len_lo;
        default:     reg_rdata <= 8'h00;
      endcase
    end
  end

  txl_fifo #(.DEPTH(FIFO_DEPTH), .W(8), .CW(CW)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (cmd_clr),
    .push    (fifo_push),
    .din     (reg_wdata),
    .pop     (pop),
    .dout    (fifo_head),
    .empty   (fifo_empty),
    .push_ok (push_acc),
    .count   (fifo_count)
  );

  txl_seq #(.LOW_MARK(LOW_MARK), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cmd_clr),
    .cmd_tx     (cmd_tx),
    .push_acc   (push_acc),
    .len        (len),
    .fifo_empty (fifo_empty),
    .fifo_count (fifo_count),
    .fifo_head  (fifo_head),
    .bit_stb    (bit_stb),
    .pop        (pop),
    .tx_bit     (tx_bit),
    .tx_vld     (tx_bit_vld),
    .busy       (tx_busy),
    .start_evt  (start_evt),
    .done_evt   (done_evt),
    .low_evt    (low_evt),
    .len_zero   (len_zero)
  );

  txl_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_evt (done_evt),
    .low_evt  (low_evt),
    .rd_clr   (rd_clr),
    .status   (status),
    .irq      (irq)
  );

endmodule

// File: rtl/txl_tx_ctrl_chk.sv
module txl_tx_ctrl_chk #(
  parameter int FIFO_DEPTH = 12,
  parameter int CW         = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [7:0]    reg_addr,
  input logic          bit_stb,
  input logic          tx_bit,
  input logic          tx_bit_vld,
  input logic          tx_busy,
  input logic          irq,
  input logic          start_evt,
  input logic          done_evt,
  input logic          low_evt,
  input logic          len_zero,
  input logic [CW-1:0] fifo_count,
  input logic [7:0]    len_hi_q
);
  localparam logic [CW-1:0] MAX_CNT = CW'(FIFO_DEPTH);

  // R4: a sent bit is always the answer to a strobe taken while sending
  a_r4_vld_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    tx_bit_vld |-> ($past(bit_stb) && $past(tx_busy)));

  // R5: no bit means a quiet data line
  a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_bit_vld |-> !tx_bit);

  // R6: completion always reaches the interrupt line
  a_r6_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> irq);

  // R7: an empty length never enters the sending state
  a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && len_zero) |=> (!tx_busy && irq));

  // R8: occupancy stays within the FIFO depth
  a_r8_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= MAX_CNT);

  // R9: a status read with no new event drops the interrupt
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 8'h0C && !done_evt && !low_evt) |=> !irq);

  // R11: the length is frozen while a message is sent
  a_r11_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && reg_wr && reg_addr == 8'h1D) |=> $stable(len_hi_q));

endmodule

bind txl_tx_ctrl txl_tx_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .bit_stb    (bit_stb),
  .tx_bit     (tx_bit),
  .tx_bit_vld (tx_bit_vld),
  .tx_busy    (tx_busy),
  .irq        (irq),
  .start_evt  (start_evt),
  .done_evt   (done_evt),
  .low_evt    (low_evt),
  .len_zero   (len_zero),
  .fifo_count (fifo_count),
  .len_hi_q   (len_hi)
);

// File: tb/txl_tx_ctrl_bench.sv
module txl_tx_ctrl_bench;

  localparam logic [7:0] A_CMD = 8'h00, A_IRQ = 8'h0C, A_HI = 8'h1D, A_LO = 8'h1E, A_FIFO = 8'h1F;

  // {len_hi, len_lo, command_first, data_seed}
  localparam logic [24:0] VEC [5] = '{
    {8'h00, 8'h10, 1'b0, 8'hA5},
    {8'h00, 8'h3B, 1'b1, 8'h3C},
    {8'h00, 8'h07, 1'b0, 8'h81},
    {8'h00, 8'h21, 1'b1, 8'h5E},
    {8'h00, 8'hAE, 1'b0, 8'h0F}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, bit_stb = 1'b0;
  logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic tx_bit, tx_bit_vld, tx_busy, irq;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  txl_tx_ctrl u_txl_tx_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_stb(bit_stb), .tx_bit(tx_bit),
    .tx_bit_vld(tx_bit_vld), .tx_busy(tx_busy), .irq(irq)
  );

  function automatic logic [7:0] byte_at(input logic [7:0] s, input int i);
    return s + 8'(i * 37);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic strobe(output logic b, output logic v);
    @(negedge clk); bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0; b = tx_bit; v = tx_bit_vld;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Sends n whole bytes from index first; returns the count of bad bits.
  task automatic send_bytes(input logic [7:0] seed, input int first, input int n, output int errs);
    logic b, v;
    errs = 0;
    for (int k = first; k < first + n; k++) begin
      logic [7:0] d;
      d = byte_at(seed, k);
      for (int j = 0; j < 8; j++) begin
        strobe(b, v);
        if (!v || b !== d[j]) errs++;
      end
    end
  endtask

  task automatic run_vec(input logic [24:0] vec);
    logic [7:0] hi, lo, seed, st;
    logic mode, b, v;
    int nwhole, pb, nbytes, errs;
    hi = vec[24:17]; lo = vec[16:9]; mode = vec[8]; seed = vec[7:0];
    nwhole = int'({hi, lo[7:4]});
    pb = (lo[0] && lo[3:1] != 3'd0) ? int'(lo[3:1]) : 0;
    nbytes = nwhole + ((pb != 0) ? 1 : 0);
    if (!mode) begin
      wr(A_HI, hi); wr(A_LO, lo);
      for (int i = 0; i < nbytes; i++) wr(A_FIFO, byte_at(seed, i));
      wr(A_CMD, 8'h01);
    end else begin
      wr(A_CMD, 8'h01); wr(A_HI, hi); wr(A_LO, lo);
      for (int i = 0; i < nbytes; i++) wr(A_FIFO, byte_at(seed, i));
    end
    repeat (2) @(negedge clk);
    errs = 0;
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] d;
      int nb;
      d = byte_at(seed, k);
      nb = (k < nwhole) ? 8 : pb;
      for (int j = 0; j < nb; j++) begin
        strobe(b, v);
        if (!v || b !== d[j]) errs++;
      end
    end
    check(errs == 0, mode ? "R3 R4 command-first bitstream" : "R2 R4 preload bitstream", errs, 0);
    strobe(b, v);
    check(!v && !b, "R5 strobe after end", int'({v, b}), 0);
    check(!tx_busy && irq, "R6 busy/irq at end", int'({tx_busy, irq}), 1);
    rd(A_IRQ, st);
    check(st[7], "R6 done flag bit7", int'(st), 8'h80);
    check(!irq, "R9 irq after read", int'(irq), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic b, v;
    int errs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    check(!tx_busy && !irq && !tx_bit_vld && !tx_bit, "R12 outputs after reset",
          int'({tx_busy, irq, tx_bit_vld, tx_bit}), 0);
    rd(A_HI, d);
    check(d == 8'h00, "R12 length high after reset", int'(d), 0);

    // R1: readback of the low length register
    wr(A_LO, 8'h3B); rd(A_LO, d);
    check(d == 8'h3B, "R1 length low readback", int'(d), 8'h3B);

    // Vector table: both start orders, partial bytes, N=0 partial flag
    for (int i = 0; i < 5; i++) run_vec(VEC[i]);

    // R7: zero length completes at once
    wr(A_HI, 8'h00); wr(A_LO, 8'h00); wr(A_FIFO, 8'h77); wr(A_CMD, 8'h01);
    check(irq && !tx_busy, "R7 zero length completion", int'({irq, tx_busy}), 2);
    rd(A_IRQ, d);
    check(d == 8'h80, "R7 zero length status", int'(d), 8'h80);
    wr(A_CMD, 8'h02);

    // R5: stall on empty FIFO mid-message, then resume
    wr(A_CMD, 8'h01); wr(A_HI, 8'h00); wr(A_LO, 8'h20); wr(A_FIFO, byte_at(8'h44, 0));
    repeat (2) @(negedge clk);
    send_bytes(8'h44, 0, 1, errs);
    check(errs == 0, "R3 R4 first byte before stall", errs, 0);
    strobe(b, v);
    check(!v && !b && tx_busy, "R5 stalled strobe", int'({v, b, tx_busy}), 1);
    wr(A_FIFO, byte_at(8'h44, 1));
    repeat (2) @(negedge clk);
    send_bytes(8'h44, 1, 1, errs);
    check(errs == 0 && !tx_busy, "R5 resume after stall", errs, 0);
    rd(A_IRQ, d);

    // R11: length write during transmission is ignored
    wr(A_HI, 8'h00); wr(A_LO, 8'h10); wr(A_FIFO, byte_at(8'h19, 0)); wr(A_CMD, 8'h01);
    wr(A_HI, 8'h05);
    rd(A_HI, d);
    check(d == 8'h00, "R11 length readback while busy", int'(d), 0);
    send_bytes(8'h19, 0, 1, errs);
    strobe(b, v);
    check(errs == 0 && !v && !tx_busy, "R11 message length unchanged", errs + int'(v), 0);
    rd(A_IRQ, d);

    // R8: refill warning on a 20-byte message
    wr(A_HI, 8'h01); wr(A_LO, 8'h40);
    for (int i = 0; i < 12; i++) wr(A_FIFO, byte_at(8'hC3, i));
    wr(A_CMD, 8'h01);
    repeat (2) @(negedge clk);
    send_bytes(8'hC3, 0, 2, errs);
    rd(A_IRQ, d);
    check(d == 8'h00 && errs == 0, "R8 no early warning", int'(d), 0);
    send_bytes(8'hC3, 2, 7, errs);
    check(irq == 1'b1, "R8 irq on low FIFO", int'(irq), 1);
    rd(A_IRQ, d);
    check(d == 8'h20, "R8 low flag bit5", int'(d), 8'h20);
    for (int i = 12; i < 20; i++) wr(A_FIFO, byte_at(8'hC3, i));
    send_bytes(8'hC3, 9, 11, errs);
    check(errs == 0 && !tx_busy, "R8 R4 refilled message", errs, 0);
    rd(A_IRQ, d);
    check(d == 8'h80, "R6 R8 final status", int'(d), 8'h80);

    // R10: reset command flushes the FIFO and start state
    wr(A_HI, 8'h00); wr(A_LO, 8'h30);
    for (int i = 0; i < 3; i++) wr(A_FIFO, byte_at(8'h2A, i));
    wr(A_CMD, 8'h02);
    wr(A_CMD, 8'h01);
    check(!tx_busy, "R10 command after flush arms only", int'(tx_busy), 0);
    wr(A_FIFO, 8'hD2);
    repeat (2) @(negedge clk);
    errs = 0;
    for (int j = 0; j < 8; j++) begin
      strobe(b, v);
      if (!v || b !== d_bit(8'hD2, j)) errs++;
    end
    check(errs == 0, "R10 first byte after flush is new data", errs, 0);
    wr(A_CMD, 8'h02);
    strobe(b, v);
    check(!tx_busy && !v, "R10 reset stops transmission", int'({tx_busy, v}), 0);
    rd(A_IRQ, d);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic logic d_bit(input logic [7:0] x, input int j);
    return x[j];
  endfunction

endmodule